// File: doc/BRIEF.md
# Descending Linked-List Sorter

This block takes sixteen 8-bit unsigned values in parallel and returns the nonzero ones in descending order, together with the slot each one came from. A single start strobe captures all sixteen values. The block then finds the lowest-numbered nonzero slot, which becomes the head of a list. It chains every later nonzero slot behind the head in ascending slot order. Zero slots never enter the list.

The list is ordered by repeated bubble passes that walk it from head to tail. Each clock cycle compares one pair of neighbouring nodes. When the later node holds the larger value, the two nodes trade their contents. Passes repeat until one completes with no exchange. A final walk then copies the list into a result table that is read by position. Two cases skip the pass phase entirely: a list with no nodes, and a list with a single node.

After the result is ready, the done flag stays high until the next accepted start. Slot `i` occupies bits `[8*i+7 : 8*i]` of the input bus. Position 0 of the result holds the largest value.

Top module: `desc_list_sorter`

## Requirements
- R1: After reset, `done` and `busy` are 0, `res_len` is 0, and every result position reads value 0 and index 0.
- R2: A `start` that is high on a clock edge while the block is idle or done captures all slot values and clears the previous result. `done` falls and `busy` rises after that edge.
- R3: When every slot is zero, `done` rises on the second edge, counting the edge that sampled `start` as the first, and `res_len` is 0.
- R4: When exactly one slot is nonzero, no sort pass runs. `done` rises on the fourth edge, `res_len` is 1, and position 0 holds that value and its slot number.
- R5: Positions 0 to L-1 hold the nonzero input values in non-increasing order, where L is the number of nonzero slots. Positions L and above read value 0.
- R6: Equal values keep ascending slot order, so the sort is stable. The slot number of each value is read at `res_idx`.
- R7: For L of 2 or more, `done` rises on edge 3 + P·(L−1) + L. Here P counts bubble passes over the list, including the final pass with no exchange. Each comparison takes one cycle. `busy` is high on exactly the edges before that one.
- R8: `res_len` equals the number of nonzero slots.
- R9: `done` and the result stay unchanged until the next accepted `start`.
- R10: A `start` that arrives while `busy` is high is ignored. The run in progress finishes with its original values and its original timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, sampled on a rising edge |
| vals_in | input | 128 | Sixteen 8-bit slot values; slot i at bits [8i+7:8i] |
| rd_pos | input | 4 | Result position to read; 0 is the largest |
| busy | output | 1 | A sort is in progress |
| done | output | 1 | Result valid; held until the next accepted start |
| res_len | output | 5 | Number of nonzero slots |
| res_val | output | 8 | Value at position rd_pos |
| res_idx | output | 4 | Original slot of the value at position rd_pos |

## Verification
The edge on which `done` is due depends only on the input values. It is two edges after the start for an empty input and four for a single entry. Otherwise it is 3 + P·(L−1) + L edges, where the bench obtains P by running its own stable bubble sort on a queue of the nonzero entries. After every edge the bench compares `done` and `busy` with that count, sampling on the falling edge. It keeps comparing for three edges past the due edge to confirm that `done` holds. The result table is read combinationally once `done` is up, and each position is compared against the sorted queue.

// File: rtl/desc_list_sorter.sv
module desc_list_sorter #(
  parameter int N     = 16,
  parameter int W     = 8,
  parameter int PTR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [N*W-1:0]           vals_in,
  input  logic [$clog2(N)-1:0]     rd_pos,
  output logic                     busy,
  output logic                     done,
  output logic [$clog2(N+1)-1:0]   res_len,
  output logic [W-1:0]             res_val,
  output logic [$clog2(N)-1:0]     res_idx
);
  localparam int IW = $clog2(N);
  localparam int LW = $clog2(N+1);
  localparam logic [PTR_W-1:0] NULLP = {PTR_W{1'b1}};

  typedef enum logic [2:0] {S_IDLE, S_FIND, S_LINK, S_SORT, S_EMIT, S_DONE} st_t;
  st_t state;

  logic [W-1:0]     val   [N];
  logic [IW-1:0]    ix    [N];
  logic [PTR_W-1:0] nxt   [N];
  logic [W-1:0]     o_val [N];
  logic [IW-1:0]    o_idx [N];
  logic [PTR_W-1:0] head, tail, cur;
  logic [IW-1:0]    pos;
  logic             swp;

  logic [PTR_W-1:0] lnxt [N];
  logic [PTR_W-1:0] first, ltail;
  logic [LW-1:0]    lcnt;

  always_comb begin
    logic [PTR_W-1:0] run;
    run   = NULLP;
    ltail = NULLP;
    lcnt  = '0;
    for (int i = N-1; i >= 0; i--) begin
      lnxt[i] = run;
      if (val[i] != '0) begin
        run  = PTR_W'(i);
        lcnt = lcnt + 1'b1;
        if (ltail == NULLP) ltail = PTR_W'(i);
      end
    end
    first = run;
  end

  logic [IW-1:0]    a, b;
  logic             do_swap;
  logic [PTR_W-1:0] nx_a;

  assign a       = cur[IW-1:0];
  assign nx_a    = nxt[a];
  assign b       = nx_a[IW-1:0];
  assign do_swap = val[a] < val[b];

  assign busy    = (state != S_IDLE) && (state != S_DONE);
  assign done    = (state == S_DONE);
  assign res_val = o_val[rd_pos];
  assign res_idx = o_idx[rd_pos];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      head    <= NULLP;
      tail    <= NULLP;
      cur     <= NULLP;
      pos     <= '0;
      swp     <= 1'b0;
      res_len <= '0;
      for (int i = 0; i < N; i++) begin
        val[i]   <= '0;
        ix[i]    <= '0;
        nxt[i]   <= NULLP;
        o_val[i] <= '0;
        o_idx[i] <= '0;
      end
    end else begin
      case (state)
        S_IDLE, S_DONE: begin
          if (start) begin
            for (int i = 0; i < N; i++) begin
              val[i]   <= vals_in[i*W +: W];
              ix[i]    <= IW'(i);
              nxt[i]   <= NULLP;
              o_val[i] <= '0;
              o_idx[i] <= '0;
            end
            head    <= NULLP;
            tail    <= NULLP;
            res_len <= '0;
            state   <= S_FIND;
          end
        end
        S_FIND: begin
          head  <= first;
          state <= (first == NULLP) ? S_DONE : S_LINK;
        end
        S_LINK: begin
          for (int i = 0; i < N; i++) nxt[i] <= lnxt[i];
          tail    <= ltail;
          res_len <= lcnt;
          cur     <= head;
          swp     <= 1'b0;
          pos     <= '0;
          state   <= (ltail == head) ? S_EMIT : S_SORT;
        end
        S_SORT: begin
          if (do_swap) begin
            val[a] <= val[b];
            val[b] <= val[a];
            ix[a]  <= ix[b];
            ix[b]  <= ix[a];
          end
          if (nx_a == tail) begin
            cur <= head;
            swp <= 1'b0;
            if (!(swp || do_swap)) state <= S_EMIT;
          end else begin
            cur <= nx_a;
            swp <= swp | do_swap;
          end
        end
        S_EMIT: begin
          o_val[pos] <= val[a];
          o_idx[pos] <= ix[a];
          pos        <= pos + 1'b1;
          if (cur == tail) state <= S_DONE;
          else             cur   <= nx_a;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r3_empty_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FIND && first == NULLP) |=> (done && res_len == '0));

  a_r4_single_no_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LINK && ltail == head) |=> ##1 (done && res_len == LW'(1)));

  a_r5_emit_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EMIT && pos != '0) |-> (val[a] <= o_val[pos - 1'b1]));

  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(res_len)));

  a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (state != S_FIND));
endmodule

// File: tb/sim_desc_list_sorter.sv
module sim_desc_list_sorter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] vin = '0;
  logic [3:0]   rd_pos = '0;
  logic         busy, done;
  logic [4:0]   res_len;
  logic [7:0]   res_val;
  logic [3:0]   res_idx;

  int checks = 0;
  int errors = 0;

  desc_list_sorter u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .vals_in(vin), .rd_pos(rd_pos),
    .busy(busy), .done(done), .res_len(res_len), .res_val(res_val), .res_idx(res_idx)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int v[16], input bit poke, input string tag);
    int qv[$];
    int qi[$];
    int L, P, D, t;
    bit sw;
    for (int i = 0; i < 16; i++) if (v[i] != 0) begin qv.push_back(v[i]); qi.push_back(i); end
    L = qv.size();
    P = 0;
    if (L >= 2) begin
      do begin
        sw = 0;
        for (int j = 0; j < L-1; j++) if (qv[j] < qv[j+1]) begin
          t = qv[j]; qv[j] = qv[j+1]; qv[j+1] = t;
          t = qi[j]; qi[j] = qi[j+1]; qi[j+1] = t;
          sw = 1;
        end
        P++;
      end while (sw);
    end
    D = (L == 0) ? 2 : (L == 1) ? 4 : 3 + P*(L-1) + L;
    @(negedge clk);
    for (int i = 0; i < 16; i++) vin[i*8 +: 8] = 8'(v[i]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= D + 3; k++) begin
      chk(done == (k >= D), $sformatf("%s R7 done edge %0d", tag, k), done, k >= D);
      chk(busy == (k < D), $sformatf("%s R2 busy edge %0d", tag, k), busy, k < D);
      if (k > D) chk(res_len == 5'(L), $sformatf("%s R9 hold", tag), res_len, L);
      if (poke && k == 3) begin vin = {16{8'h33}}; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
    end
    chk(res_len == 5'(L), $sformatf("%s R8 length", tag), res_len, L);
    for (int p = 0; p < 16; p++) begin
      rd_pos = 4'(p);
      #1;
      if (p < L) begin
        chk(res_val == 8'(qv[p]), $sformatf("%s R5 value pos %0d", tag, p), res_val, qv[p]);
        chk(res_idx == 4'(qi[p]), $sformatf("%s R6 index pos %0d", tag, p), res_idx, qi[p]);
      end else begin
        chk(res_val == 8'd0, $sformatf("%s R5 empty pos %0d", tag, p), res_val, 0);
      end
    end
    rd_pos = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v[16];
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(res_len == 5'd0, "R1 reset length", res_len, 0);
    #1;
    chk(res_val == 8'd0 && res_idx == 4'd0, "R1 reset result", res_val, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1 idle after reset", done, 0);

    v = '{default: 0};
    run_case(v, 0, "R3 all-zero");

    v = '{default: 0}; v[9] = 7;
    run_case(v, 0, "R4 single");

    v = '{default: 0}; v[2] = 3; v[11] = 200;
    run_case(v, 0, "two");

    v = '{default: 0}; v[0] = 5; v[1] = 10; v[2] = 15; v[3] = 12; v[4] = 8; v[5] = 14;
    run_case(v, 0, "six");

    v = '{default: 0}; v[0] = 4; v[1] = 9; v[2] = 4; v[4] = 9; v[5] = 4;
    run_case(v, 0, "R6 ties");

    for (int i = 0; i < 16; i++) v[i] = i + 1;
    run_case(v, 0, "full-ascending");

    for (int i = 0; i < 16; i++) v[i] = 255 - 3*i;
    run_case(v, 0, "full-presorted");

    v = '{default: 0}; v[0] = 5; v[1] = 10; v[2] = 15; v[3] = 12; v[4] = 8; v[5] = 14;
    run_case(v, 1, "R10 start-while-busy");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule